// File: doc/BRIEF.md
# Temperature Alarm Status Logic

This block turns a stream of signed 16-bit temperature samples into two status flags, one for over-temperature and one for under-temperature, plus a single alarm level. Each flag has a trip threshold and a release threshold that sits on the safe side of the trip point. Each new sample is compared against both thresholds. A fault queue requires a programmable number of consecutive out-of-limit samples before a flag may assert.

In comparator mode a flag follows the temperature with hysteresis. In interrupt mode a flag is an event latch. It sets on a crossing and stays set until software reads the status, and the read clears it. After that clear, the flag waits for the opposite crossing, so it reports entry to and exit from the fault region in turn. A shutdown input clears all flag state. The alarm output combines both flags and applies a selectable polarity. The host bus, the converter and the output pad are outside this block.

Top module: `temp_alarm_status`

## Requirements
- R1: Comparator mode (intr_mode_i=0), high side: ot_o becomes 1 after a qualified sample strictly greater than hi_trip_i. It becomes 0 after a sample strictly less than hi_rel_i. A sample equal to either threshold changes neither. All comparisons are signed.
- R2: Comparator mode, low side: ut_o becomes 1 after a qualified sample strictly less than lo_trip_i. It becomes 0 after a sample strictly greater than lo_rel_i. A sample equal to either threshold changes neither.
- R3: Interrupt mode (intr_mode_i=1): a flag with value 0 sets on a qualified crossing of the edge it is waiting for, and it then stays 1 until stat_rd_i clears it. The first edge it waits for is the trip crossing. After each set, the flag waits for the other edge: for OT, a rise above hi_trip_i alternates with a fall below hi_rel_i. UT mirrors this with lo_trip_i and lo_rel_i.
- R4: In comparator mode stat_rd_i has no effect on ot_o or ut_o.
- R5: While shutdown_i is 1, both flags are 0 on the next cycle, and samples are ignored. Fault counts and the interrupt wait state return to their initial values.
- R6: fq_code_i selects the number of consecutive qualifying samples needed before a flag asserts: codes 0, 1, 2 and 3 select 1, 2, 4 and 8. A valid sample that does not qualify resets the count to zero.
- R7: alarm_o equals ot_o OR ut_o when pol_high_i is 1, and the inverse of that when pol_high_i is 0.
- R8: After reset both flags are 0, and alarm_o shows the inactive level.
- R9: Flags change only on the rising clock edge on which smp_vld_i=1, except for a clear by read or by shutdown. The result is visible directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | New temperature sample present |
| smp_temp_i | input | 16 | Signed sample, 0.0625 °C per LSB |
| hi_trip_i | input | 16 | Over-temperature trip threshold |
| hi_rel_i | input | 16 | Over-temperature release threshold |
| lo_trip_i | input | 16 | Under-temperature trip threshold |
| lo_rel_i | input | 16 | Under-temperature release threshold |
| intr_mode_i | input | 1 | 0 = comparator, 1 = interrupt |
| pol_high_i | input | 1 | 1 = alarm active high, 0 = active low |
| fq_code_i | input | 2 | Fault queue depth code |
| stat_rd_i | input | 1 | Status register read strobe |
| shutdown_i | input | 1 | Shutdown request |
| ot_o | output | 1 | Over-temperature status |
| ut_o | output | 1 | Under-temperature status |
| alarm_o | output | 1 | Alarm level with polarity applied |

## Verification
A fault counter that is off by one shows up as a flag that rises one sample early or late. This is seen on the first trip crossing after a miss, so the sweep breaks up its samples with in-limit values. A wrong interrupt wait state shows up after the first read: the flag sets again on the same edge, or stays dark on the opposite crossing. This is seen within one ramp of the temperature. A flag that survives shutdown or ignores the polarity shows on the first cycle after the stimulus, because every output is compared after every edge against an arithmetic model.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef enum logic {
    WATCH_TRIP = 1'b0,
    WATCH_REL  = 1'b1
  } arm_e;

endpackage

// File: rtl/ta_limit_cmp.sv
module ta_limit_cmp #(
  parameter int DW      = 16,
  parameter bit IS_HIGH = 1'b1
) (
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [DW-1:0] trip_i,
  input  logic signed [DW-1:0] rel_i,
  output logic                 beyond_o,
  output logic                 back_o
);

  generate
    if (IS_HIGH) begin : g_high
      always_comb begin
        beyond_o = smp_i > trip_i;
        back_o   = smp_i < rel_i;
      end
    end else begin : g_low
      always_comb begin
        beyond_o = smp_i < trip_i;
        back_o   = smp_i > rel_i;
      end
    end
  endgenerate

endmodule

// File: rtl/ta_fault_queue.sv
module ta_fault_queue #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o
);

  localparam int CNT_W = 1 << CODE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] need_w;
  logic [CNT_W-1:0] inc_w;
  logic             reach_w;

  always_comb begin
    need_w  = CNT_W'(1) << code_i;
    inc_w   = cnt_q + CNT_W'(1);
    reach_w = inc_w >= need_w;
    fire_o  = en_i && !clr_i && hit_i && reach_w;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      if (!hit_i)       cnt_d = '0;
      else if (reach_w) cnt_d = need_w;
      else              cnt_d = inc_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R6: a miss on an accepted sample empties the queue
  a_r6_miss_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hit_i) |=> (cnt_q == '0));

endmodule

// File: rtl/ta_flag_channel.sv
module ta_flag_channel
  import ta_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CODE_W  = 2,
  parameter bit IS_HIGH = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [DW-1:0] trip_i,
  input  logic signed [DW-1:0] rel_i,
  input  logic                 intr_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic                 rd_i,
  input  logic                 sd_i,
  output logic                 flag_o
);

  logic beyond_w;
  logic back_w;
  logic event_w;
  logic cnt_en_w;
  logic cnt_clr_w;
  logic fire_w;
  logic flag_q;
  logic flag_d;
  arm_e arm_q;
  arm_e arm_d;

  ta_limit_cmp #(.DW(DW), .IS_HIGH(IS_HIGH)) u_cmp (
    .smp_i    (smp_i),
    .trip_i   (trip_i),
    .rel_i    (rel_i),
    .beyond_o (beyond_w),
    .back_o   (back_w)
  );

  always_comb begin
    event_w   = (intr_i && arm_q == WATCH_REL) ? back_w : beyond_w;
    cnt_clr_w = sd_i || (intr_i && flag_q);
    cnt_en_w  = vld_i && !sd_i;
  end

  ta_fault_queue #(.CODE_W(CODE_W)) u_fq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_w),
    .en_i   (cnt_en_w),
    .hit_i  (event_w),
    .code_i (code_i),
    .fire_o (fire_w)
  );

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (sd_i) begin
      flag_d = 1'b0;
      arm_d  = WATCH_TRIP;
    end else if (!intr_i) begin
      arm_d = WATCH_TRIP;
      if (fire_w)                    flag_d = 1'b1;
      else if (vld_i && back_w)      flag_d = 1'b0;
    end else begin
      if (flag_q) begin
        if (rd_i) flag_d = 1'b0;
      end else if (fire_w) begin
        flag_d = 1'b1;
        arm_d  = (arm_q == WATCH_TRIP) ? WATCH_REL : WATCH_TRIP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= WATCH_TRIP;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R5: shutdown empties flag and wait state
  a_r5_sd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |=> (!flag_q && arm_q == WATCH_TRIP));

  // R3: an interrupt flag holds until read
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_i && flag_q && !rd_i && !sd_i) |=> flag_q);

  // R9: a flag only rises on an accepted sample
  a_r9_rise_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !vld_i) |=> !flag_q);

  // R1 and R2: a release crossing in comparator mode drops the flag
  a_r1_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intr_i && vld_i && !sd_i && back_w && !beyond_w) |=> !flag_q);

  // R4: without a sample the comparator flag holds, whatever the read strobe
  a_r4_rd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intr_i && !vld_i && !sd_i && $stable(intr_i)) |=> (flag_q == $past(flag_q)));

endmodule

// File: rtl/temp_alarm_status.sv
module temp_alarm_status #(
  parameter int DW     = 16,
  parameter int CODE_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_vld_i,
  input  logic signed [DW-1:0] smp_temp_i,
  input  logic signed [DW-1:0] hi_trip_i,
  input  logic signed [DW-1:0] hi_rel_i,
  input  logic signed [DW-1:0] lo_trip_i,
  input  logic signed [DW-1:0] lo_rel_i,
  input  logic                 intr_mode_i,
  input  logic                 pol_high_i,
  input  logic [CODE_W-1:0]    fq_code_i,
  input  logic                 stat_rd_i,
  input  logic                 shutdown_i,
  output logic                 ot_o,
  output logic                 ut_o,
  output logic                 alarm_o
);

  localparam int NCH = 2;

  logic [1:0]          rst_sync_q;
  logic                rst_n_w;
  logic signed [DW-1:0] trip_w [NCH];
  logic signed [DW-1:0] rel_w  [NCH];
  logic [NCH-1:0]      flag_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_w = rst_sync_q[1];

  always_comb begin
    trip_w[0] = lo_trip_i;
    rel_w[0]  = lo_rel_i;
    trip_w[1] = hi_trip_i;
    rel_w[1]  = hi_rel_i;
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      ta_flag_channel #(
        .DW      (DW),
        .CODE_W  (CODE_W),
        .IS_HIGH (g == 1)
      ) u_ch (
        .clk_i  (clk_i),
        .rst_ni (rst_n_w),
        .vld_i  (smp_vld_i),
        .smp_i  (smp_temp_i),
        .trip_i (trip_w[g]),
        .rel_i  (rel_w[g]),
        .intr_i (intr_mode_i),
        .code_i (fq_code_i),
        .rd_i   (stat_rd_i),
        .sd_i   (shutdown_i),
        .flag_o (flag_w[g])
      );
    end
  endgenerate

  assign ot_o    = flag_w[1];
  assign ut_o    = flag_w[0];
  assign alarm_o = (ot_o | ut_o) ^ ~pol_high_i;

  // R8: flags are clear during reset
  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_n_w |=> (rst_n_w || (!ot_o && !ut_o)));

endmodule

// File: tb/tb_temp_alarm_status.sv
module tb_temp_alarm_status;

  localparam int TH  = 1600;
  localparam int THH = 1440;
  localparam int TL  = -640;
  localparam int TLH = -480;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic signed [15:0] temp = '0;
  logic intr = 1'b0;
  logic pol = 1'b1;
  logic [1:0] code = 2'd0;
  logic rd = 1'b0;
  logic sd = 1'b0;
  logic ot, ut, alarm;

  int nvec = 0;
  int nfail = 0;
  int mflag [2];
  int marm [2];
  int mcnt [2];

  always #2 clk = ~clk;

  temp_alarm_status dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_vld_i   (vld),
    .smp_temp_i  (temp),
    .hi_trip_i   (16'(TH)),
    .hi_rel_i    (16'(THH)),
    .lo_trip_i   (16'(TL)),
    .lo_rel_i    (16'(TLH)),
    .intr_mode_i (intr),
    .pol_high_i  (pol),
    .fq_code_i   (code),
    .stat_rd_i   (rd),
    .shutdown_i  (sd),
    .ot_o        (ot),
    .ut_o        (ut),
    .alarm_o     (alarm)
  );

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(bit v, int t, bit r, bit s);
    for (int c = 0; c < 2; c++) begin
      int  need;
      bit  trip, back, ev, fire;
      need = 1 << code;
      trip = (c == 1) ? (t > TH)  : (t < TL);
      back = (c == 1) ? (t < THH) : (t > TLH);
      if (s) begin
        mflag[c] = 0; marm[c] = 0; mcnt[c] = 0;
      end else if (!intr) begin
        marm[c] = 0;
        if (v) begin
          if (trip) begin
            fire = (mcnt[c] + 1 >= need);
            mcnt[c] = fire ? need : mcnt[c] + 1;
            if (fire) mflag[c] = 1;
          end else begin
            mcnt[c] = 0;
            if (back) mflag[c] = 0;
          end
        end
      end else begin
        if (mflag[c] != 0) begin
          mcnt[c] = 0;
          if (r) mflag[c] = 0;
        end else if (v) begin
          ev = (marm[c] != 0) ? back : trip;
          if (ev) begin
            fire = (mcnt[c] + 1 >= need);
            mcnt[c] = fire ? need : mcnt[c] + 1;
            if (fire) begin
              mflag[c] = 1;
              marm[c] = (marm[c] != 0) ? 0 : 1;
            end
          end else begin
            mcnt[c] = 0;
          end
        end
      end
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic apply(bit v, int t, bit r, bit s);
    vld = v; temp = 16'(t); rd = r; sd = s;
    @(posedge clk);
    model_step(v, t, r, s);
    #1;
    if (intr) begin
      chk("R3 ot", int'(ot), mflag[1]);
      chk("R3 ut", int'(ut), mflag[0]);
    end else begin
      chk("R1 ot", int'(ot), mflag[1]);
      chk("R2 ut", int'(ut), mflag[0]);
    end
    chk("R7 alarm", int'(alarm), ((mflag[0] | mflag[1]) != 0) ? int'(pol) : int'(!pol));
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int n;
    for (int c = 0; c < 2; c++) begin mflag[c] = 0; marm[c] = 0; mcnt[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state, active-high polarity
    chk("R8 ot", int'(ot), 0);
    chk("R8 ut", int'(ut), 0);
    chk("R8 alarm", int'(alarm), 0);

    // R9: an invalid hot sample changes nothing
    apply(0, 2000, 0, 0);
    chk("R9 ot", int'(ot), 0);

    // R6: code 2 needs four consecutive hot samples
    code = 2'd2;
    apply(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) begin apply(1, 2000, 0, 0); chk("R6 early", int'(ot), 0); end
    apply(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin apply(1, 2000, 0, 0); chk("R6 broken", int'(ot), 0); end
    apply(1, 2000, 0, 0);
    chk("R6 fourth", int'(ot), 1);

    // R1: a sample equal to the release threshold keeps the flag
    apply(1, THH, 0, 0);
    chk("R1 equal", int'(ot), 1);

    // R4: read in comparator mode has no effect
    apply(0, 0, 1, 0);
    chk("R4 read", int'(ot), 1);

    // R5: shutdown clears and blocks samples
    apply(0, 0, 0, 1);
    chk("R5 clear", int'(ot), 0);
    apply(1, 2000, 0, 1);
    chk("R5 held", int'(ot), 0);

    // R3: interrupt sequence, code 0
    intr = 1'b1; code = 2'd0;
    apply(1, 2000, 0, 0); chk("R3 set", int'(ot), 1);
    apply(1, 2000, 0, 0); chk("R3 hold", int'(ot), 1);
    apply(0, 0, 1, 0);    chk("R3 read", int'(ot), 0);
    apply(1, 2000, 0, 0); chk("R3 no reset", int'(ot), 0);
    apply(1, 1000, 0, 0); chk("R3 rearm", int'(ot), 1);
    apply(0, 0, 1, 0);
    apply(1, -1000, 0, 0); chk("R3 ut", int'(ut), 1);

    // sweep every mode, queue depth and polarity over ramps
    for (int m = 0; m < 2; m++) begin
      for (int q = 0; q < 4; q++) begin
        for (int p = 0; p < 2; p++) begin
          intr = 1'(m); code = 2'(q); pol = 1'(p);
          apply(0, 0, 0, 1);
          n = 0;
          for (int lap = 0; lap < 2; lap++) begin
            for (int k = 0; k < 142; k++) begin
              int t;
              bit v, r, s;
              t = (k < 71) ? (-880 + 40 * k) : (1960 - 40 * (k - 70));
              if (n % 7 == 3) t = 0;
              v = (n % 5 != 4);
              r = (n % 11 == 6);
              s = (n == 150);
              apply(v, t, r, s);
              n++;
            end
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule